// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Front End with Timed Interrupts

This block is the register face of a classic byte-oriented serial port. A host reaches it over a small bus with a 3-bit offset and single-byte reads and writes. Received characters arrive on an input byte stream with a valid/ready handshake. Characters the host writes leave on an output byte stream as one-cycle pulses. There is no shift register, no baud generator and no FIFO. The transmitter is always reported empty, and the divisor-latch locations accept accesses but discard them.

Interrupts are not raised at once. A "receive data" or "transmit holding empty" condition starts a per-source down-counter of `DELAY_CYC` clock cycles. A pending bit is set only when that counter expires, and the single level interrupt output is the OR of the two pending bits. When the transmit interrupt is enabled, a holdoff rule applies. If the last transmit interrupt was posted more than one delay period ago, the new one is posted at once. Otherwise it goes through the timer.

Top module: `uart_irq_front`

## Requirements
- R1: After reset the interrupt output is low, the control byte (offset 3), the modem control byte (offset 4) and the enable byte (offset 1) read 0x00, and the identification byte (offset 2) reads 0x01.
- R2: With control bit 7 clear, a read of offset 0 returns the waiting received byte and consumes it (ready high for that cycle). It returns 0x00 when nothing waits, and it clears the receive pending bit.
- R3: With control bit 7 clear, a write to offset 0 drives that byte on the output stream with a one-cycle valid pulse one cycle later. The write also clears the transmit pending bit and, when enable bit 1 is set, restarts the transmit timer.
- R4: With control bit 7 set, accesses to offsets 0 and 1 have no effect: no byte is emitted, no received byte is consumed, reads return 0x00, and the enable byte keeps its value.
- R5: An identification read returns 0x04 while a receive interrupt is pending. Otherwise it returns 0x02 while a transmit interrupt is pending, and 0x01 when neither is pending.
- R6: An identification read clears the transmit pending bit only when it returned 0x02. A read that returned 0x04 leaves the transmit pending bit set.
- R7: A read of offset 5 returns bits 6 and 5 set, with bit 0 set exactly when a received byte is waiting and all other bits clear.
- R8: Offsets 3 and 4 read back the last byte written to them. Offset 1 reads back the enable byte while control bit 7 is clear.
- R9: A scheduled interrupt sets its pending bit exactly `DELAY_CYC` clock edges after the edge that scheduled it. Scheduling again while the timer runs restarts it from the full delay.
- R10: A write of offset 1 with bit 1 set posts the transmit interrupt on that edge if more than `DELAY_CYC` cycles have passed since the last transmit post (or since reset). Otherwise the write starts the transmit timer.
- R11: A write of offset 1 with enable bit 1 (transmit) or bit 0 (receive) clear stops the matching timer and clears that pending bit, so the interrupt drops on the next cycle when the other source is idle.
- R12: While enable bit 0 is set, a waiting byte with no receive interrupt pending and no receive timer running starts the receive timer. This covers a new arrival and the next byte after a read. A receive timer that expires with no byte waiting sets nothing.
- R13: Every read returns its data on the read-data port, with read-valid high, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rx_valid | input | 1 | A received byte is waiting |
| rx_data | input | 8 | The waiting received byte |
| rx_ready | output | 1 | Received byte consumed this cycle |
| tx_valid | output | 1 | Outgoing byte pulse |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt, OR of both pending bits |

## Verification
A wrong pending bit shows up in two places. It appears on the interrupt pin, and it appears in the very next identification read, which returns a code that does not match the pin level of the request cycle. A wrong timer or holdoff state shows up as an interrupt edge that comes a delay period early or late. The bench therefore times the delay to the exact clock edge and samples the pin on both sides of it. A wrong control-bit-7 state shows at once: a byte appears on the output stream, or the receive stream loses a byte that later reads cannot return.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA = 3'd0,
    OFS_IEN  = 3'd1,
    OFS_IDENT = 3'd2,
    OFS_LCTL = 3'd3,
    OFS_MCTL = 3'd4,
    OFS_LSTAT = 3'd5
  } reg_ofs_e;

  // enable byte bit positions
  localparam int EN_RX_BIT = 0;
  localparam int EN_TX_BIT = 1;
  // control byte: divisor access select
  localparam int LC_DIV_BIT = 7;

  localparam logic [BYTE_W-1:0] ID_RX   = 8'h04;
  localparam logic [BYTE_W-1:0] ID_TX   = 8'h02;
  localparam logic [BYTE_W-1:0] ID_NONE = 8'h01;

  localparam logic [BYTE_W-1:0] LS_EMPTY = 8'h60;
  localparam int LS_READY_BIT = 0;
endpackage

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int DELAY_CYC = 45,
  localparam int CNT_W = $clog2(DELAY_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cancel,
  output logic running,
  output logic fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign running = run_q;
  assign fire    = run_q && (cnt_q == CNT_W'(1)) && !start && !cancel;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (cancel) begin
      run_q <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(DELAY_CYC);
    end else if (run_q) begin
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tx_holdoff.sv
module tx_holdoff #(
  parameter int DELAY_CYC = 45,
  localparam int LIM = DELAY_CYC + 1,
  localparam int CNT_W = $clog2(LIM + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic post,
  output logic expired
);
  logic [CNT_W-1:0] age_q;

  assign expired = (age_q > CNT_W'(DELAY_CYC));

  always_ff @(posedge clk) begin
    if (rst) age_q <= CNT_W'(LIM);
    else if (post) age_q <= '0;
    else if (age_q != CNT_W'(LIM)) age_q <= age_q + 1'b1;
  end
endmodule

// File: rtl/uart_irq_front.sv
module uart_irq_front
  import uart_irq_pkg::*;
#(
  parameter int DELAY_CYC = 45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              rd_valid,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  logic [BYTE_W-1:0] ien_q, lcr_q, mcr_q;
  logic              rx_pend, tx_pend;

  logic dlab, acc_rd, acc_wr, data_rd, data_wr, ien_wr, id_rd;
  logic wr_tx_en, wr_rx_en;
  logic tx_start, tx_cancel, tx_fire, tx_run, tx_now, hold_exp;
  logic rx_start, rx_cancel, rx_fire, rx_run;

  assign dlab    = lcr_q[LC_DIV_BIT];
  assign acc_rd  = bus_req && !bus_we;
  assign acc_wr  = bus_req && bus_we;
  assign data_rd = acc_rd && (bus_addr == OFS_DATA) && !dlab;
  assign data_wr = acc_wr && (bus_addr == OFS_DATA) && !dlab;
  assign ien_wr  = acc_wr && (bus_addr == OFS_IEN) && !dlab;
  assign id_rd   = acc_rd && (bus_addr == OFS_IDENT);

  assign wr_tx_en = bus_wdata[EN_TX_BIT];
  assign wr_rx_en = bus_wdata[EN_RX_BIT];

  assign rx_ready = data_rd && rx_valid;

  // transmit scheduling
  assign tx_now    = ien_wr && wr_tx_en && hold_exp;
  assign tx_start  = (data_wr && ien_q[EN_TX_BIT]) || (ien_wr && wr_tx_en && !hold_exp);
  assign tx_cancel = (ien_wr && !wr_tx_en) || tx_now;

  // receive scheduling
  assign rx_start  = (ien_wr && wr_rx_en && rx_valid) ||
                     (ien_q[EN_RX_BIT] && rx_valid && !rx_pend && !rx_run && !data_rd && !ien_wr);
  assign rx_cancel = ien_wr && !wr_rx_en;

  irq_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tx_tmr (
    .clk(clk), .rst(rst), .start(tx_start), .cancel(tx_cancel),
    .running(tx_run), .fire(tx_fire)
  );

  irq_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_rx_tmr (
    .clk(clk), .rst(rst), .start(rx_start), .cancel(rx_cancel),
    .running(rx_run), .fire(rx_fire)
  );

  tx_holdoff #(.DELAY_CYC(DELAY_CYC)) u_hold (
    .clk(clk), .rst(rst), .post(tx_fire || tx_now), .expired(hold_exp)
  );

  // pending bits and registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= '0;
      lcr_q   <= '0;
      mcr_q   <= '0;
      rx_pend <= 1'b0;
      tx_pend <= 1'b0;
    end else begin
      if (ien_wr) ien_q <= bus_wdata;
      if (acc_wr && bus_addr == OFS_LCTL) lcr_q <= bus_wdata;
      if (acc_wr && bus_addr == OFS_MCTL) mcr_q <= bus_wdata;

      if (tx_fire || tx_now) tx_pend <= 1'b1;
      if (data_wr || (ien_wr && !wr_tx_en) || (id_rd && !rx_pend && tx_pend))
        tx_pend <= 1'b0;

      if (rx_fire && rx_valid) rx_pend <= 1'b1;
      if (data_rd || rx_cancel) rx_pend <= 1'b0;
    end
  end

  assign irq = rx_pend || tx_pend;

  // outgoing stream
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= data_wr;
      if (data_wr) tx_data <= bus_wdata;
    end
  end

  // registered read path
  logic [BYTE_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_DATA:  rd_mux = (!dlab && rx_valid) ? rx_data : '0;
      OFS_IEN:   rd_mux = dlab ? '0 : ien_q;
      OFS_IDENT: rd_mux = rx_pend ? ID_RX : (tx_pend ? ID_TX : ID_NONE);
      OFS_LCTL:  rd_mux = lcr_q;
      OFS_MCTL:  rd_mux = mcr_q;
      OFS_LSTAT: begin
        rd_mux = LS_EMPTY;
        rd_mux[LS_READY_BIT] = rx_valid;
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      rd_valid <= acc_rd;
      if (acc_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/uart_irq_front_chk.sv
module uart_irq_front_chk
  import uart_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              rd_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              irq,
  input logic [BYTE_W-1:0] lcr_q
);
  // R5
  id_matches_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(bus_addr) == OFS_IDENT) |-> ((bus_rdata == ID_NONE) == !$past(irq)));

  // R7
  lstat_empty_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(bus_addr) == OFS_LSTAT) |-> (bus_rdata[6:5] == 2'b11));

  // R3
  tx_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_req && bus_we && bus_addr == OFS_DATA && !lcr_q[LC_DIV_BIT]));

  // R2
  rx_pop_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (bus_req && !bus_we && bus_addr == OFS_DATA && !lcr_q[LC_DIV_BIT]));

  // R11
  disable_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == OFS_IEN && !lcr_q[LC_DIV_BIT] && bus_wdata[1:0] == 2'b00)
      |=> !irq);

  // R13
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_req && !bus_we));
endmodule

bind uart_irq_front uart_irq_front_chk u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_valid(rd_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .irq(irq), .lcr_q(lcr_q)
);

// File: tb/uart_irq_front_bench.sv
`timescale 1ns/1ps
module uart_irq_front_bench;
  localparam int D = 45;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_we = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, tx_data, rx_data;
  logic rd_valid, rx_valid, rx_ready, tx_valid, irq;

  always #2.5 clk = ~clk;

  // receive source
  logic [7:0] rx_mem [16];
  logic [3:0] rx_rd = '0, rx_wr = '0;
  assign rx_valid = (rx_rd != rx_wr);
  assign rx_data  = rx_mem[rx_rd];
  always @(posedge clk) if (rx_ready) rx_rd <= rx_rd + 1'b1;

  uart_irq_front #(.DELAY_CYC(D)) u_uart_irq_front (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_valid(rd_valid),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  int errors = 0, checks = 0, tx_seen = 0;
  logic [7:0] rd_exp_q[$], tx_exp_q[$];
  string      rd_tag_q[$];
  bit         done = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_rx(logic [7:0] b);
    rx_mem[rx_wr] = b;
    rx_wr = rx_wr + 1'b1;
  endtask

  task automatic bus_wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_rd(logic [2:0] a, logic [7:0] exp, string tag);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: reads and outgoing bytes
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (rd_exp_q.size() == 0) check(0, "R13 unexpected read data", bus_rdata, 0);
      else begin
        automatic logic [7:0] e = rd_exp_q.pop_front();
        automatic string t = rd_tag_q.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
    if (!rst && tx_valid) begin
      tx_seen++;
      if (tx_exp_q.size() == 0) check(0, "R4 unexpected output byte", tx_data, 0);
      else begin
        automatic logic [7:0] e = tx_exp_q.pop_front();
        check(tx_data == e, "R3 output byte", tx_data, e);
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst = 0;
    wait_cyc(1);
    // R1 reset state
    check(irq == 0, "R1 irq after reset", irq, 0);
    bus_rd(3'd2, 8'h01, "R1 ident after reset");
    bus_rd(3'd3, 8'h00, "R1 control after reset");
    bus_rd(3'd4, 8'h00, "R1 modem ctl after reset");
    bus_rd(3'd1, 8'h00, "R1 enable after reset");
    bus_rd(3'd5, 8'h60, "R7 status empty");
    bus_rd(3'd0, 8'h00, "R2 empty data read");

    // R8 readback
    bus_wr(3'd3, 8'h03);
    bus_wr(3'd4, 8'h0B);
    bus_rd(3'd3, 8'h03, "R8 control readback");
    bus_rd(3'd4, 8'h0B, "R8 modem ctl readback");

    // R3 byte out, no interrupt when disabled
    tx_exp_q.push_back(8'h41);
    bus_wr(3'd0, 8'h41);
    wait_cyc(D + 10);
    check(irq == 0, "R3 no irq while disabled", irq, 0);

    // R10 immediate post after long idle
    bus_wr(3'd1, 8'h02);
    check(irq == 1, "R10 immediate transmit post", irq, 1);
    bus_rd(3'd2, 8'h02, "R5 ident transmit");
    bus_rd(3'd2, 8'h01, "R6 cleared by reporting read");
    wait_cyc(1);
    check(irq == 0, "R6 irq low after report", irq, 0);

    // R10 delayed post, R9 exact delay
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd1, 8'h02);
    check(irq == 0, "R10 held off", irq, 0);
    wait_cyc(D - 1);
    check(irq == 0, "R9 one edge before expiry", irq, 0);
    wait_cyc(1);
    check(irq == 1, "R9 exact expiry", irq, 1);

    // R3 write clears and reschedules
    tx_exp_q.push_back(8'h55);
    bus_wr(3'd0, 8'h55);
    check(irq == 0, "R3 data write clears transmit", irq, 0);
    wait_cyc(D + 2);
    check(irq == 1, "R3 transmit rescheduled", irq, 1);
    bus_rd(3'd2, 8'h02, "R5 ident transmit again");

    // R11 cancel
    bus_wr(3'd1, 8'h02);
    bus_wr(3'd1, 8'h00);
    wait_cyc(D + 15);
    check(irq == 0, "R11 cancelled timer", irq, 0);

    // receive path, priority
    push_rx(8'hA5);
    bus_rd(3'd5, 8'h61, "R7 data ready bit");
    bus_rd(3'd2, 8'h01, "R5 nothing pending with rx disabled");
    bus_wr(3'd1, 8'h01);
    wait_cyc(D + 2);
    check(irq == 1, "R12 receive interrupt", irq, 1);
    bus_rd(3'd2, 8'h04, "R5 ident receive");
    bus_wr(3'd1, 8'h03);
    bus_rd(3'd2, 8'h04, "R5 receive priority");
    bus_rd(3'd0, 8'hA5, "R2 data read");
    bus_rd(3'd2, 8'h02, "R6 transmit kept after receive report");
    bus_rd(3'd2, 8'h01, "R5 none pending");
    wait_cyc(D + 15);
    check(irq == 0, "R12 expiry without data dropped", irq, 0);

    // R12 back-to-back bytes
    bus_wr(3'd1, 8'h01);
    push_rx(8'h11);
    push_rx(8'h22);
    wait_cyc(D + 5);
    check(irq == 1, "R12 arrival schedules", irq, 1);
    bus_rd(3'd0, 8'h11, "R2 first byte");
    check(irq == 0, "R2 read clears receive", irq, 0);
    wait_cyc(D + 5);
    check(irq == 1, "R12 next byte schedules", irq, 1);
    bus_rd(3'd0, 8'h22, "R2 second byte");
    bus_rd(3'd2, 8'h01, "R5 drained");
    wait_cyc(D + 5);
    check(irq == 0, "R12 idle after drain", irq, 0);

    // R4 divisor select hides data and enable
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd3, 8'h80);
    bus_wr(3'd0, 8'h99);
    push_rx(8'h77);
    bus_rd(3'd0, 8'h00, "R4 data read hidden");
    bus_rd(3'd1, 8'h00, "R4 enable read hidden");
    bus_wr(3'd1, 8'h03);
    bus_wr(3'd3, 8'h03);
    bus_rd(3'd1, 8'h00, "R4 enable unchanged");
    bus_rd(3'd0, 8'h77, "R4 byte not consumed");
    wait_cyc(4);
    check(tx_seen == 2, "R4 output byte count", tx_seen, 2);
    check(rd_exp_q.size() == 0, "R13 all reads returned", rd_exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule